// File: doc/BRIEF.md
# Dual-Width Scan Test Wrapper

This block sits around an embedded core and turns its nine internal scan chains, together with one boundary cell per functional input and per functional output, into wrapper scan chains driven from a test access bus. One set of cells can be stitched two ways. In narrow mode the wrapper forms four chains that are driven by a 4-bit bus. In wide mode it forms six chains that are driven by a 6-bit bus. Each arrangement is balanced for its own bus width. The narrow one has a scan-in depth of 20 and a worst scan-out depth of 21, so one pattern costs 41 shift cycles. The wide one has 14 for both depths, so one pattern costs 28 shift cycles.

Each boundary cell is a single flop. When scan enable is high, it takes the bit of its predecessor in the active arrangement. When scan enable is low, it captures its functional value. An input cell captures its pin, and an output cell captures the core output it watches. The core's own chains shift under the same scan enable. The wrapper drives each chain's serial input and reads back its serial output. The width select is sampled only in cycles with scan enable low, so a test program sets the mode between patterns.

Top module: `dual_tam_wrapper`

## Requirements
- R1: While reset is asserted and after it is released, every boundary cell holds 0 and the wrapper is in narrow mode, whatever the width select. Both bus outputs read 0 until shifting brings non-zero data to them.
- R2: In every clock with scan_en low, input cell i loads func_in[i] and output cell j loads core_fo[j]. Internal chain contents are not disturbed.
- R3: In narrow mode (tam_sel sampled 0), bit w of the 4-bit bus runs through the following cells, in order from serial input to serial output:
  - w=0: core chain 0, then core chain 2.
  - w=1: core chain 1, core chain 3, output cell 0.
  - w=2: input cells 0..5, core chains 4 and 5, output cells 1..7.
  - w=3: input cells 6 and 7, core chains 6, 7 and 8, output cells 8..10.
  - Core chain lengths, for chains 0..8, are 12, 12, 8, 8, 8, 6, 6, 6, 6.
- R4: In wide mode (tam_sel sampled 1), bit w of the 6-bit bus runs through the following cells, in order from serial input to serial output:
  - w=0: core chain 0, output cells 0 and 1.
  - w=1: input cells 0 and 1, core chain 1, output cell 2.
  - w=2: core chains 2 and 5.
  - w=3: core chains 3 and 6.
  - w=4: core chains 4 and 7.
  - w=5: input cells 2..7, core chain 8, output cells 3..10.
- R5: After a capture, the input cell nearest the core on a chain reaches that chain's bus output after exactly its scan-out depth in shift cycles. This is 21 cycles for input cell 5 on narrow bit 2, and 14 cycles for input cell 7 on wide bit 5.
- R6: The mode register follows tam_sel only at clock edges where scan_en is low. A change of tam_sel while shifting has no effect on routing.
- R7: The bus belonging to the inactive mode drives all zeros on its outputs, and its inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | 1 = shift all chains, 0 = capture into boundary cells |
| tam_sel | input | 1 | Width request, 0 = 4-bit bus, 1 = 6-bit bus (sampled while scan_en is low) |
| func_in | input | 8 | Functional input pins captured by the input cells |
| core_fo | input | 11 | Core functional outputs captured by the output cells |
| core_so | input | 9 | Serial outputs of the core's internal scan chains |
| core_si | output | 9 | Serial inputs driven into the core's internal scan chains |
| tam4_in | input | 4 | Narrow bus scan data in |
| tam4_out | output | 4 | Narrow bus scan data out |
| tam6_in | input | 6 | Wide bus scan data in |
| tam6_out | output | 6 | Wide bus scan data out |

## Verification
The hardest case to reach is a routing fault that mixes cells from the two arrangements. Such a fault shows up only after a pattern is captured in one mode and the bits travel through segments that are shared with the other mode. The stimulus therefore switches width between patterns and drives random data on the idle bus. It checks every shifted bit against a model that walks the cell order of each chain. Separate directed runs do three things. They hold the select high through reset. They toggle the select in the middle of a shift. They flush the chains, capture ones only in the input cells, and count the cycles until the first one reaches the bus.

// File: rtl/tw_pkg.sv
package tw_pkg;

   localparam int unsigned FI_CNT = 8;
   localparam int unsigned FO_CNT = 11;
   localparam int unsigned CH_CNT = 9;
   localparam int unsigned TAM_N  = 4;
   localparam int unsigned TAM_W  = 6;
   localparam int unsigned IDX_W  = 4;

   typedef enum logic [1:0] {
      SRC_TAM = 2'd0,
      SRC_IC  = 2'd1,
      SRC_OC  = 2'd2,
      SRC_SO  = 2'd3
   } src_kind_e;

   typedef struct packed {
      src_kind_e        kind;
      logic [IDX_W-1:0] idx;
   } src_t;

   typedef enum logic {
      MODE_N = 1'b0,
      MODE_W = 1'b1
   } tam_mode_e;

   function automatic src_t f_t(int unsigned i);
      return '{kind: SRC_TAM, idx: IDX_W'(i)};
   endfunction
   function automatic src_t f_i(int unsigned i);
      return '{kind: SRC_IC, idx: IDX_W'(i)};
   endfunction
   function automatic src_t f_o(int unsigned i);
      return '{kind: SRC_OC, idx: IDX_W'(i)};
   endfunction
   function automatic src_t f_s(int unsigned i);
      return '{kind: SRC_SO, idx: IDX_W'(i)};
   endfunction

   // Predecessor of every sink, narrow arrangement
   localparam src_t IC_MAP_N [FI_CNT] = '{
      f_t(2), f_i(0), f_i(1), f_i(2), f_i(3), f_i(4), f_t(3), f_i(6)};
   localparam src_t OC_MAP_N [FO_CNT] = '{
      f_s(3), f_s(5), f_o(1), f_o(2), f_o(3), f_o(4), f_o(5), f_o(6),
      f_s(8), f_o(8), f_o(9)};
   localparam src_t CH_MAP_N [CH_CNT] = '{
      f_t(0), f_t(1), f_s(0), f_s(1), f_i(5), f_s(4), f_i(7), f_s(6), f_s(7)};
   localparam src_t OUT_MAP_N [TAM_N] = '{
      f_s(2), f_o(0), f_o(7), f_o(10)};

   // Predecessor of every sink, wide arrangement
   localparam src_t IC_MAP_W [FI_CNT] = '{
      f_t(1), f_i(0), f_t(5), f_i(2), f_i(3), f_i(4), f_i(5), f_i(6)};
   localparam src_t OC_MAP_W [FO_CNT] = '{
      f_s(0), f_o(0), f_s(1), f_s(8), f_o(3), f_o(4), f_o(5), f_o(6),
      f_o(7), f_o(8), f_o(9)};
   localparam src_t CH_MAP_W [CH_CNT] = '{
      f_t(0), f_i(1), f_t(2), f_t(3), f_t(4), f_s(2), f_s(3), f_s(4), f_i(7)};
   localparam src_t OUT_MAP_W [TAM_W] = '{
      f_o(1), f_o(2), f_s(5), f_s(6), f_s(7), f_o(10)};

endpackage

// File: rtl/tw_mode_reg.sv
module tw_mode_reg
   import tw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      scan_en,
   input  logic      sel,
   output tam_mode_e mode_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_q <= MODE_N;
      else if (!scan_en) mode_q <= sel ? MODE_W : MODE_N;
   end

   // R6: the arrangement never changes at an edge where shifting was requested
   p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> $stable(mode_q));

   // R6: a capture edge adopts the requested width
   p_mode_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> (mode_q == MODE_W) == $past(sel));

endmodule

// File: rtl/tw_cell_bank.sv
module tw_cell_bank #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic [N-1:0] cap_d,
   input  logic [N-1:0] shift_d,
   output logic [N-1:0] q
);

   if (N < 1) begin : g_bad_n
      $error("tw_cell_bank needs at least one cell");
   end

   for (genvar gi = 0; gi < N; gi++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[gi] <= 1'b0;
         else        q[gi] <= shift_en ? shift_d[gi] : cap_d[gi];
      end
   end

   // R2: capture edge loads the functional value
   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> q == $past(cap_d));

   // R3: shift edge loads the predecessor bit
   p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> q == $past(shift_d));

endmodule

// File: rtl/tw_route.sv
module tw_route
   import tw_pkg::*;
#(
   parameter int unsigned NI = FI_CNT,
   parameter int unsigned NO = FO_CNT,
   parameter int unsigned NC = CH_CNT,
   parameter int unsigned NT = TAM_W
) (
   input  src_t          src,
   input  logic [NT-1:0] tam_v,
   input  logic [NI-1:0] ic_q,
   input  logic [NO-1:0] oc_q,
   input  logic [NC-1:0] so,
   output logic          bit_o
);

   localparam int unsigned SPAN = 1 << IDX_W;

   if (NI > SPAN || NO > SPAN || NC > SPAN || NT > SPAN) begin : g_bad_span
      $error("tw_route index field too narrow for the source vectors");
   end

   logic b_tam, b_ic, b_oc, b_so;

   always_comb begin
      b_tam = 1'b0;
      for (int k = 0; k < NT; k++) if (src.idx == IDX_W'(k)) b_tam = tam_v[k];
   end
   always_comb begin
      b_ic = 1'b0;
      for (int k = 0; k < NI; k++) if (src.idx == IDX_W'(k)) b_ic = ic_q[k];
   end
   always_comb begin
      b_oc = 1'b0;
      for (int k = 0; k < NO; k++) if (src.idx == IDX_W'(k)) b_oc = oc_q[k];
   end
   always_comb begin
      b_so = 1'b0;
      for (int k = 0; k < NC; k++) if (src.idx == IDX_W'(k)) b_so = so[k];
   end

   always_comb begin
      unique case (src.kind)
         SRC_TAM: bit_o = b_tam;
         SRC_IC:  bit_o = b_ic;
         SRC_OC:  bit_o = b_oc;
         SRC_SO:  bit_o = b_so;
         default: bit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/dual_tam_wrapper.sv
module dual_tam_wrapper
   import tw_pkg::*;
#(
   parameter int unsigned N_FI = FI_CNT,
   parameter int unsigned N_FO = FO_CNT,
   parameter int unsigned N_CH = CH_CNT,
   parameter int unsigned N_TN = TAM_N,
   parameter int unsigned N_TW = TAM_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scan_en,
   input  logic            tam_sel,
   input  logic [N_FI-1:0] func_in,
   input  logic [N_FO-1:0] core_fo,
   input  logic [N_CH-1:0] core_so,
   output logic [N_CH-1:0] core_si,
   input  logic [N_TN-1:0] tam4_in,
   output logic [N_TN-1:0] tam4_out,
   input  logic [N_TW-1:0] tam6_in,
   output logic [N_TW-1:0] tam6_out
);

   if (N_FI != FI_CNT || N_FO != FO_CNT || N_CH != CH_CNT) begin : g_bad_core
      $error("dual_tam_wrapper: core shape must match the stitching tables");
   end
   if (N_TN != TAM_N || N_TW != TAM_W || N_TN >= N_TW) begin : g_bad_bus
      $error("dual_tam_wrapper: bus widths must match the stitching tables");
   end

   tam_mode_e       mode_q;
   logic            wide;
   logic [N_TW-1:0] tam_v;
   logic [N_FI-1:0] ic_q, ic_sd;
   logic [N_FO-1:0] oc_q, oc_sd;
   logic [N_TN-1:0] outn_b;
   logic [N_TW-1:0] outw_b;

   tw_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .scan_en (scan_en),
      .sel     (tam_sel),
      .mode_q  (mode_q)
   );

   assign wide  = (mode_q == MODE_W);
   assign tam_v = wide ? tam6_in : N_TW'(tam4_in);

   tw_cell_bank #(.N(N_FI)) u_icells (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (scan_en),
      .cap_d    (func_in),
      .shift_d  (ic_sd),
      .q        (ic_q)
   );

   tw_cell_bank #(.N(N_FO)) u_ocells (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (scan_en),
      .cap_d    (core_fo),
      .shift_d  (oc_sd),
      .q        (oc_q)
   );

   for (genvar gi = 0; gi < N_FI; gi++) begin : g_ic
      src_t pick;
      assign pick = wide ? IC_MAP_W[gi] : IC_MAP_N[gi];
      tw_route #(.NI(N_FI), .NO(N_FO), .NC(N_CH), .NT(N_TW)) u_rt (
         .src (pick), .tam_v (tam_v), .ic_q (ic_q), .oc_q (oc_q),
         .so  (core_so), .bit_o (ic_sd[gi]));
   end

   for (genvar gi = 0; gi < N_FO; gi++) begin : g_oc
      src_t pick;
      assign pick = wide ? OC_MAP_W[gi] : OC_MAP_N[gi];
      tw_route #(.NI(N_FI), .NO(N_FO), .NC(N_CH), .NT(N_TW)) u_rt (
         .src (pick), .tam_v (tam_v), .ic_q (ic_q), .oc_q (oc_q),
         .so  (core_so), .bit_o (oc_sd[gi]));
   end

   for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
      src_t pick;
      assign pick = wide ? CH_MAP_W[gi] : CH_MAP_N[gi];
      tw_route #(.NI(N_FI), .NO(N_FO), .NC(N_CH), .NT(N_TW)) u_rt (
         .src (pick), .tam_v (tam_v), .ic_q (ic_q), .oc_q (oc_q),
         .so  (core_so), .bit_o (core_si[gi]));
   end

   for (genvar gi = 0; gi < N_TN; gi++) begin : g_outn
      tw_route #(.NI(N_FI), .NO(N_FO), .NC(N_CH), .NT(N_TW)) u_rt (
         .src (OUT_MAP_N[gi]), .tam_v (tam_v), .ic_q (ic_q), .oc_q (oc_q),
         .so  (core_so), .bit_o (outn_b[gi]));
   end

   for (genvar gi = 0; gi < N_TW; gi++) begin : g_outw
      tw_route #(.NI(N_FI), .NO(N_FO), .NC(N_CH), .NT(N_TW)) u_rt (
         .src (OUT_MAP_W[gi]), .tam_v (tam_v), .ic_q (ic_q), .oc_q (oc_q),
         .so  (core_so), .bit_o (outw_b[gi]));
   end

   assign tam4_out = wide ? '0 : outn_b;
   assign tam6_out = wide ? outw_b : '0;

   // R7: idle bus stays quiet
   p_idle_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_W) |-> (tam4_out == '0));
   p_idle_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_N) |-> (tam6_out == '0));

   // R1: first edge after reset release is still in narrow mode
   p_reset_mode_r1: assert property (@(posedge clk)
      !rst_n |=> (mode_q == MODE_N) || $past(!scan_en && tam_sel && rst_n));

endmodule

// File: tb/dual_tam_wrapper_tb_top.sv
module dual_tam_wrapper_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scan_en = 1'b0;
   logic        tam_sel = 1'b0;
   logic [7:0]  func_in = '0;
   logic [10:0] core_fo = '0;
   logic [8:0]  core_so;
   logic [8:0]  core_si;
   logic [3:0]  tam4_in = '0;
   logic [3:0]  tam4_out;
   logic [5:0]  tam6_in = '0;
   logic [5:0]  tam6_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   dual_tam_wrapper dut_i (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .tam_sel(tam_sel),
      .func_in(func_in), .core_fo(core_fo), .core_so(core_so), .core_si(core_si),
      .tam4_in(tam4_in), .tam4_out(tam4_out), .tam6_in(tam6_in), .tam6_out(tam6_out));

   // Stand-in core: nine plain shift chains
   int chl [9] = '{12, 12, 8, 8, 8, 6, 6, 6, 6};
   logic [11:0] core_chn [9];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 9; k++) core_chn[k] <= '0;
      end else if (scan_en) begin
         for (int k = 0; k < 9; k++) core_chn[k] <= {core_chn[k][10:0], core_si[k]};
      end
   end

   always_comb begin
      for (int k = 0; k < 9; k++) core_so[k] = core_chn[k][chl[k]-1];
   end

   // Reference model: physical cell state plus per-mode cell orderings
   bit ric [8];
   bit roc [11];
   bit rch [9][12];
   int ref_mode = 0;
   int dk [2][6][40];
   int di [2][6][40];
   int db [2][6][40];
   int dl [2][6];
   int nch [2] = '{4, 6};
   logic [3:0] obs4;
   logic [5:0] obs6;

   task automatic add_ic(int m, int w, int first, int cnt);
      for (int c = 0; c < cnt; c++) begin
         dk[m][w][dl[m][w]] = 0; di[m][w][dl[m][w]] = first + c; db[m][w][dl[m][w]] = 0;
         dl[m][w]++;
      end
   endtask

   task automatic add_oc(int m, int w, int first, int cnt);
      for (int c = 0; c < cnt; c++) begin
         dk[m][w][dl[m][w]] = 1; di[m][w][dl[m][w]] = first + c; db[m][w][dl[m][w]] = 0;
         dl[m][w]++;
      end
   endtask

   task automatic add_ch(int m, int w, int k);
      for (int b = 0; b < chl[k]; b++) begin
         dk[m][w][dl[m][w]] = 2; di[m][w][dl[m][w]] = k; db[m][w][dl[m][w]] = b;
         dl[m][w]++;
      end
   endtask

   task automatic build_orders();
      for (int m = 0; m < 2; m++) for (int w = 0; w < 6; w++) dl[m][w] = 0;
      // narrow (R3)
      add_ch(0, 0, 0); add_ch(0, 0, 2);
      add_ch(0, 1, 1); add_ch(0, 1, 3); add_oc(0, 1, 0, 1);
      add_ic(0, 2, 0, 6); add_ch(0, 2, 4); add_ch(0, 2, 5); add_oc(0, 2, 1, 7);
      add_ic(0, 3, 6, 2); add_ch(0, 3, 6); add_ch(0, 3, 7); add_ch(0, 3, 8); add_oc(0, 3, 8, 3);
      // wide (R4)
      add_ch(1, 0, 0); add_oc(1, 0, 0, 2);
      add_ic(1, 1, 0, 2); add_ch(1, 1, 1); add_oc(1, 1, 2, 1);
      add_ch(1, 2, 2); add_ch(1, 2, 5);
      add_ch(1, 3, 3); add_ch(1, 3, 6);
      add_ch(1, 4, 4); add_ch(1, 4, 7);
      add_ic(1, 5, 2, 6); add_ch(1, 5, 8); add_oc(1, 5, 3, 8);
   endtask

   function automatic bit rget(int m, int w, int p);
      case (dk[m][w][p])
         0:       return ric[di[m][w][p]];
         1:       return roc[di[m][w][p]];
         default: return rch[di[m][w][p]][db[m][w][p]];
      endcase
   endfunction

   task automatic rset(int m, int w, int p, bit v);
      case (dk[m][w][p])
         0:       ric[di[m][w][p]] = v;
         1:       roc[di[m][w][p]] = v;
         default: rch[di[m][w][p]][db[m][w][p]] = v;
      endcase
   endtask

   task automatic compare_outputs();
      logic [3:0] e4 = '0;
      logic [5:0] e6 = '0;
      for (int w = 0; w < nch[ref_mode]; w++) begin
         if (ref_mode == 1) e6[w] = rget(1, w, dl[1][w] - 1);
         else               e4[w] = rget(0, w, dl[0][w] - 1);
      end
      checks++;
      if (tam4_out !== e4) begin
         fails++;
         $display("FAIL %s: tam4_out=%h expected %h", (ref_mode == 0) ? "R2 R3" : "R7", tam4_out, e4);
      end
      checks++;
      if (tam6_out !== e6) begin
         fails++;
         $display("FAIL %s: tam6_out=%h expected %h", (ref_mode == 1) ? "R2 R4" : "R7", tam6_out, e6);
      end
   endtask

   task automatic ref_edge(bit se, bit sel, logic [3:0] t4, logic [5:0] t6,
                           logic [7:0] fi, logic [10:0] fo);
      if (se) begin
         for (int w = 0; w < nch[ref_mode]; w++) begin
            for (int p = dl[ref_mode][w] - 1; p > 0; p--)
               rset(ref_mode, w, p, rget(ref_mode, w, p - 1));
            rset(ref_mode, w, 0, (ref_mode == 1) ? t6[w] : t4[w]);
         end
      end else begin
         for (int i = 0; i < 8; i++)  ric[i] = fi[i];
         for (int j = 0; j < 11; j++) roc[j] = fo[j];
         ref_mode = sel ? 1 : 0;
      end
   endtask

   task automatic step(bit se, bit sel, logic [3:0] t4, logic [5:0] t6,
                       logic [7:0] fi, logic [10:0] fo);
      @(negedge clk);
      scan_en = se; tam_sel = sel; tam4_in = t4; tam6_in = t6;
      func_in = fi; core_fo = fo;
      #2;
      obs4 = tam4_out;
      obs6 = tam6_out;
      compare_outputs();
      @(posedge clk);
      ref_edge(se, sel, t4, t6, fi, fo);
   endtask

   task automatic run_pattern(bit wide, int nin, int nout, bit wiggle);
      for (int c = 0; c < nin; c++)
         step(1'b1, wide, 4'($urandom), 6'($urandom), 8'($urandom), 11'($urandom));
      step(1'b0, wide, 4'($urandom), 6'($urandom), 8'($urandom), 11'($urandom));
      for (int c = 0; c < nout; c++) begin
         step(1'b1, wiggle ? ~wide : wide, 4'($urandom), 6'($urandom), 8'($urandom), 11'($urandom));
         if (wiggle && wide) begin
            checks++;
            if (obs4 !== 4'h0) begin
               fails++;
               $display("FAIL R6: tam4_out=%h expected 0 after select toggled mid-shift", obs4);
            end
         end
      end
   endtask

   task automatic latency(bit wide, int bit_idx, int expect_n);
      int seen = -1;
      step(1'b0, wide, 4'h0, 6'h0, 8'h00, 11'h000);
      for (int c = 0; c < 30; c++) step(1'b1, wide, 4'h0, 6'h0, 8'h00, 11'h000);
      step(1'b0, wide, 4'h0, 6'h0, 8'hFF, 11'h000);
      for (int c = 0; c < 30; c++) begin
         step(1'b1, wide, 4'h0, 6'h0, 8'h00, 11'h000);
         if (seen < 0 && (wide ? obs6[bit_idx] : obs4[bit_idx]) === 1'b1) seen = c;
      end
      checks++;
      if (seen != expect_n) begin
         fails++;
         $display("FAIL R5: first captured input bit after %0d shifts expected %0d", seen, expect_n);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      build_orders();
      for (int i = 0; i < 8; i++) ric[i] = 0;
      for (int j = 0; j < 11; j++) roc[j] = 0;
      for (int k = 0; k < 9; k++) for (int b = 0; b < 12; b++) rch[k][b] = 0;

      // R1: reset with the wide request held high
      tam_sel = 1'b1; scan_en = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (tam4_out !== 4'h0 || tam6_out !== 6'h0) begin
         fails++;
         $display("FAIL R1: outputs %h/%h during reset expected 0/0", tam4_out, tam6_out);
      end
      rst_n = 1'b1;
      step(1'b1, 1'b1, 4'h0, 6'h3F, 8'h00, 11'h000);
      checks++;
      if (obs6 !== 6'h0) begin
         fails++;
         $display("FAIL R1: tam6_out=%h after reset expected 0 (narrow mode)", obs6);
      end

      // R2/R3 directed capture then unload on the narrow bus
      step(1'b0, 1'b0, 4'h0, 6'h15, 8'hA5, 11'h5A3);
      for (int c = 0; c < 21; c++) step(1'b1, 1'b0, 4'h0, 6'($urandom), 8'h00, 11'h000);

      // R3: random narrow patterns, 20 in + capture + 21 out
      for (int n = 0; n < 5; n++) run_pattern(1'b0, 20, 21, 1'b0);
      latency(1'b0, 2, 21);   // R5 narrow

      // R4: switch to wide, random patterns, 14 in + capture + 14 out
      for (int n = 0; n < 4; n++) run_pattern(1'b1, 14, 14, 1'b0);
      for (int n = 0; n < 2; n++) run_pattern(1'b1, 14, 14, 1'b1);   // R6
      latency(1'b1, 5, 14);   // R5 wide

      // back to narrow: R6 capture edge adopts the select, R7 idle wide bus
      for (int n = 0; n < 2; n++) run_pattern(1'b0, 20, 21, 1'b1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule